// File: doc/BRIEF.md
# Frame Metadata Line Inserter

This block sits in front of a camera serial packetizer. At every frame start it captures one consistent snapshot of the sensor's status words: frame number, analog and digital gain, integration time, crop window, orientation and temperature. It then sends that snapshot as a metadata line before any pixel line of the frame. The line is a byte stream with line-start and line-end markers. Each byte carries a data type and a virtual channel, and the metadata line uses its own pair of these values, separate from the pixel lines.

Pixel lines arrive on a valid/ready input and pass through unchanged while no metadata line is due. While a metadata line is pending or being sent, the block holds `pix_ready` low, so the upstream source must wait and no pixel byte is lost. If a frame start arrives in the middle of a pixel line, the capture happens at once, but the metadata line waits until that pixel line has ended.

The output follows valid/ready rules. During a metadata line, a byte that is offered stays offered, and does not change, until `out_ready` takes it. During pass-through, the output simply mirrors the pixel source, and the source must follow the same holding rule.

The payload is 512 bytes. The 16-bit frame number comes first, then status word k, each least-significant byte first. Zeros fill the rest of the 512 bytes. The line can optionally be stretched to the active pixel line length with padding bytes. Insertion can be switched off, but only while the device is not streaming.

Suggested word use: word0 analog gain, word1 digital gain, word2 integration time, word3 crop origin, word4 crop size, word5 orientation, word6 temperature, word7 spare.

Top module: `emb_status_inserter`

## Requirements
- R1: After an accepted frame start with insertion enabled, the metadata line is output before any pixel line that starts later. A frame start is accepted only while `streaming` is high and no metadata line is pending or in flight.
- R2: Metadata byte layout:
  - bytes 0 and 1 hold the frame number, low byte first;
  - bytes 2+4k to 5+4k hold status word k, least-significant byte first;
  - every further byte up to byte 511 is 0x00.
- R3: If `cfg_stretch` is 1 and `cfg_line_len` is greater than 512, the line is `cfg_line_len` bytes long, and bytes 512 and above are 0x07. Otherwise the line is exactly 512 bytes.
- R4: Metadata bytes carry `cfg_emb_dt`/`cfg_emb_vc`. Pixel bytes carry `cfg_pix_dt`/`cfg_pix_vc`.
- R5: On a metadata line, `out_sol` is set on the first byte only and `out_eol` on the last byte only.
- R6: The line content is the status words and frame number as they were in the cycle the frame start was accepted. Later changes to `status_words` do not affect that line.
- R7: While insertion is disabled (`en_state`=0), frames carry no metadata line and pixel lines pass through unchanged.
- R8: A write of `cfg_en_wdata` with `cfg_en_wr` is taken only while `streaming` is low. A write made while streaming is ignored, and `en_state` keeps its value.
- R9: The 16-bit frame number starts at 0 and rises by one on every accepted frame start, whether insertion is enabled or not. It wraps from 65535 to 0. A frame start while `streaming` is low is ignored.
- R10: While a metadata line is pending or being sent, `pix_ready` is low. Every accepted pixel byte appears on the output exactly once and in order.
- R11: A frame start that comes inside a pixel line does not break that line. The metadata line begins only after the pixel line's end byte.
- R12: Once a metadata byte is offered, it stays offered and unchanged until `out_ready` accepts it.
- R13: After reset, `out_valid` is 0 with no pixel input, and `en_state` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| streaming | input | 1 | High while the device is streaming |
| cfg_en_wr | input | 1 | Write strobe for the insertion enable |
| cfg_en_wdata | input | 1 | Value to write to the insertion enable |
| en_state | output | 1 | Current insertion enable |
| cfg_stretch | input | 1 | Stretch the line to `cfg_line_len` |
| cfg_line_len | input | LEN_W | Active pixel line length in bytes |
| cfg_emb_dt | input | DT_W | Data type for metadata bytes |
| cfg_emb_vc | input | VC_W | Virtual channel for metadata bytes |
| cfg_pix_dt | input | DT_W | Data type for pixel bytes |
| cfg_pix_vc | input | VC_W | Virtual channel for pixel bytes |
| frame_start | input | 1 | Frame-start strobe |
| status_words | input | 32*STAT_WORDS | Status words; word k in bits 32k+31:32k |
| pix_valid | input | 1 | Pixel byte valid |
| pix_ready | output | 1 | Pixel byte accepted |
| pix_data | input | 8 | Pixel byte |
| pix_sol | input | 1 | First byte of a pixel line |
| pix_eol | input | 1 | Last byte of a pixel line |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Output byte |
| out_dt | output | DT_W | Data type tag |
| out_vc | output | VC_W | Virtual channel tag |
| out_sol | output | 1 | Line start marker |
| out_eol | output | 1 | Line end marker |

## Verification
The bench builds the block with its default parameters: eight status words, a 512-byte payload and a 12-bit line length. With a 12-bit length, a 600-byte stretched line and a 300-byte non-stretching request can both be tested. Because the frame number also advances while insertion is off, the bench can hold `frame_start` high for tens of thousands of cycles with no line output. The lines that follow then carry 65534, 65535 and 0, so the wrap is reached within the cycle budget. A toggling `out_ready` pattern, pixel lines offered during a metadata line, and a frame start placed halfway through a pixel line exercise the back-pressure and ordering rules.

// File: rtl/esl_pkg.sv
package esl_pkg;
  typedef enum logic [1:0] {
    ESL_IDLE = 2'd0,
    ESL_WAIT = 2'd1,
    ESL_EMIT = 2'd2
  } esl_state_e;

  localparam int unsigned ESL_FCNT_W      = 16;
  localparam int unsigned ESL_BYTE_W      = 8;
  localparam logic [7:0]  ESL_ZERO_FILL   = 8'h00;
  localparam logic [7:0]  ESL_STRETCH_PAD = 8'h07;
endpackage

// File: rtl/esl_cfg.sv
module esl_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic streaming,
  input  logic wr,
  input  logic wdata,
  output logic en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                en_q <= 1'b1;
    else if (wr && !streaming) en_q <= wdata;
  end

  // R8
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    streaming |=> $stable(en_q));
endmodule

// File: rtl/esl_snapshot.sv
module esl_snapshot
  import esl_pkg::*;
#(
  parameter int unsigned STAT_WORDS = 8,
  parameter int unsigned META_BYTES = 512,
  parameter int unsigned LEN_W      = 12,
  localparam int unsigned POP_BYTES = ESL_FCNT_W / 8 + 4 * STAT_WORDS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fs_accept,
  input  logic                      fs_capture,
  input  logic                      cfg_stretch,
  input  logic [LEN_W-1:0]          cfg_line_len,
  input  logic [32*STAT_WORDS-1:0]  status_words,
  output logic [POP_BYTES*8-1:0]    snap_o,
  output logic [LEN_W-1:0]          len_o
);
  localparam logic [LEN_W-1:0] META_LEN = LEN_W'(META_BYTES);

  logic [ESL_FCNT_W-1:0] fcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      snap_o <= '0;
      len_o  <= META_LEN;
    end else begin
      if (fs_accept) fcnt_q <= fcnt_q + ESL_FCNT_W'(1);
      if (fs_capture) begin
        snap_o <= {status_words, fcnt_q};
        len_o  <= (cfg_stretch && (cfg_line_len > META_LEN)) ? cfg_line_len : META_LEN;
      end
    end
  end

  // R9
  fcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_accept |=> fcnt_q == $past(fcnt_q) + ESL_FCNT_W'(1));

  // R9
  fcnt_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_accept |=> $stable(fcnt_q));
endmodule

// File: rtl/esl_byte_gen.sv
module esl_byte_gen
  import esl_pkg::*;
#(
  parameter int unsigned POP_BYTES  = 34,
  parameter int unsigned META_BYTES = 512,
  parameter int unsigned LEN_W      = 12
) (
  input  logic [LEN_W-1:0]       idx,
  input  logic [POP_BYTES*8-1:0] snap,
  output logic [7:0]             byte_o
);
  localparam logic [LEN_W-1:0] META_LEN = LEN_W'(META_BYTES);

  always_comb begin
    byte_o = ESL_ZERO_FILL;
    for (int b = 0; b < POP_BYTES; b++) begin
      if (idx == LEN_W'(b)) byte_o = snap[b*8 +: 8];
    end
    if (idx >= META_LEN) byte_o = ESL_STRETCH_PAD;
  end
endmodule

// File: rtl/esl_stream_mux.sv
module esl_stream_mux
  import esl_pkg::*;
#(
  parameter int unsigned LEN_W = 12,
  parameter int unsigned DT_W  = 6,
  parameter int unsigned VC_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             streaming,
  input  logic             en,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       emb_byte,
  output logic [LEN_W-1:0] idx_o,
  output logic             fs_accept,
  output logic             fs_capture,
  input  logic [DT_W-1:0]  emb_dt,
  input  logic [VC_W-1:0]  emb_vc,
  input  logic [DT_W-1:0]  pix_dt,
  input  logic [VC_W-1:0]  pix_vc,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [7:0]       pix_data,
  input  logic             pix_sol,
  input  logic             pix_eol,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic [DT_W-1:0]  out_dt,
  output logic [VC_W-1:0]  out_vc,
  output logic             out_sol,
  output logic             out_eol
);
  esl_state_e       state_q;
  logic [LEN_W-1:0] idx_q;
  logic             pix_busy_q;
  logic             emitting, last_byte, pass_ok, pix_fire;

  assign emitting   = (state_q == ESL_EMIT);
  assign last_byte  = (idx_q == len - LEN_W'(1));
  assign fs_accept  = frame_start && streaming && (state_q == ESL_IDLE);
  assign fs_capture = fs_accept && en;
  assign pass_ok    = ((state_q == ESL_IDLE) && (pix_busy_q || !fs_capture)) ||
                      ((state_q == ESL_WAIT) && pix_busy_q);
  assign pix_ready  = pass_ok && out_ready;
  assign pix_fire   = pix_valid && pix_ready;
  assign idx_o      = idx_q;

  always_comb begin
    if (emitting) begin
      out_valid = 1'b1;
      out_data  = emb_byte;
      out_dt    = emb_dt;
      out_vc    = emb_vc;
      out_sol   = (idx_q == '0);
      out_eol   = last_byte;
    end else begin
      out_valid = pix_valid && pass_ok;
      out_data  = pix_data;
      out_dt    = pix_dt;
      out_vc    = pix_vc;
      out_sol   = pix_sol;
      out_eol   = pix_eol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ESL_IDLE;
      idx_q      <= '0;
      pix_busy_q <= 1'b0;
    end else begin
      if (pix_fire) begin
        if (pix_eol)      pix_busy_q <= 1'b0;
        else if (pix_sol) pix_busy_q <= 1'b1;
      end
      unique case (state_q)
        ESL_IDLE: if (fs_capture) begin
          state_q <= pix_busy_q ? ESL_WAIT : ESL_EMIT;
          idx_q   <= '0;
        end
        ESL_WAIT: if (!pix_busy_q) state_q <= ESL_EMIT;
        ESL_EMIT: if (out_ready) begin
          if (last_byte) begin
            state_q <= ESL_IDLE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + LEN_W'(1);
          end
        end
        default: state_q <= ESL_IDLE;
      endcase
    end
  end

  // R12
  emit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emitting && !out_ready) |=> (emitting && $stable(out_data) && $stable(out_sol)));

  // R10
  pix_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ESL_IDLE) && !(state_q == ESL_WAIT && pix_busy_q) |-> !pix_ready);

  // R5
  eol_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emitting && out_ready && out_eol) |=> (state_q == ESL_IDLE));

  // R11
  wait_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ESL_IDLE && fs_capture && pix_busy_q) |=> !emitting);
endmodule

// File: rtl/emb_status_inserter.sv
module emb_status_inserter
  import esl_pkg::*;
#(
  parameter int unsigned STAT_WORDS = 8,
  parameter int unsigned META_BYTES = 512,
  parameter int unsigned LEN_W      = 12,
  parameter int unsigned DT_W       = 6,
  parameter int unsigned VC_W       = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     streaming,
  input  logic                     cfg_en_wr,
  input  logic                     cfg_en_wdata,
  output logic                     en_state,
  input  logic                     cfg_stretch,
  input  logic [LEN_W-1:0]         cfg_line_len,
  input  logic [DT_W-1:0]          cfg_emb_dt,
  input  logic [VC_W-1:0]          cfg_emb_vc,
  input  logic [DT_W-1:0]          cfg_pix_dt,
  input  logic [VC_W-1:0]          cfg_pix_vc,
  input  logic                     frame_start,
  input  logic [32*STAT_WORDS-1:0] status_words,
  input  logic                     pix_valid,
  output logic                     pix_ready,
  input  logic [7:0]               pix_data,
  input  logic                     pix_sol,
  input  logic                     pix_eol,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [7:0]               out_data,
  output logic [DT_W-1:0]          out_dt,
  output logic [VC_W-1:0]          out_vc,
  output logic                     out_sol,
  output logic                     out_eol
);
  localparam int unsigned POP_BYTES = ESL_FCNT_W / 8 + 4 * STAT_WORDS;

  logic                   fs_accept, fs_capture;
  logic [POP_BYTES*8-1:0] snap;
  logic [LEN_W-1:0]       line_len, idx;
  logic [7:0]             emb_byte;

  esl_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .streaming(streaming),
    .wr(cfg_en_wr), .wdata(cfg_en_wdata), .en_q(en_state)
  );

  esl_snapshot #(.STAT_WORDS(STAT_WORDS), .META_BYTES(META_BYTES), .LEN_W(LEN_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .fs_accept(fs_accept), .fs_capture(fs_capture),
    .cfg_stretch(cfg_stretch), .cfg_line_len(cfg_line_len),
    .status_words(status_words), .snap_o(snap), .len_o(line_len)
  );

  esl_byte_gen #(.POP_BYTES(POP_BYTES), .META_BYTES(META_BYTES), .LEN_W(LEN_W)) u_bytes (
    .idx(idx), .snap(snap), .byte_o(emb_byte)
  );

  esl_stream_mux #(.LEN_W(LEN_W), .DT_W(DT_W), .VC_W(VC_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .streaming(streaming),
    .en(en_state), .len(line_len), .emb_byte(emb_byte), .idx_o(idx),
    .fs_accept(fs_accept), .fs_capture(fs_capture),
    .emb_dt(cfg_emb_dt), .emb_vc(cfg_emb_vc), .pix_dt(cfg_pix_dt), .pix_vc(cfg_pix_vc),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .pix_sol(pix_sol), .pix_eol(pix_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_dt(out_dt), .out_vc(out_vc), .out_sol(out_sol), .out_eol(out_eol)
  );
endmodule

// File: tb/emb_status_inserter_tb.sv
`timescale 1ns/1ps
module emb_status_inserter_tb;
  localparam int SW = 8;
  localparam int META = 512;
  localparam int LW = 12;
  localparam logic [5:0] EMB_DT = 6'h12;
  localparam logic [1:0] EMB_VC = 2'd1;
  localparam logic [5:0] PIX_DT = 6'h2B;
  localparam logic [1:0] PIX_VC = 2'd0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic streaming = 1'b0, cfg_en_wr = 1'b0, cfg_en_wdata = 1'b0, en_state;
  logic cfg_stretch = 1'b0;
  logic [LW-1:0] cfg_line_len = LW'(600);
  logic frame_start = 1'b0;
  logic [31:0] w [SW];
  logic [32*SW-1:0] sw_flat;
  logic pix_valid = 1'b0, pix_ready, pix_sol = 1'b0, pix_eol = 1'b0;
  logic [7:0] pix_data = 8'h00;
  logic out_valid, out_ready = 1'b1, out_sol, out_eol;
  logic [7:0] out_data;
  logic [5:0] out_dt;
  logic [1:0] out_vc;

  always #2.5 clk = ~clk;

  always_comb for (int k = 0; k < SW; k++) sw_flat[k*32 +: 32] = w[k];

  emb_status_inserter #(.STAT_WORDS(SW), .META_BYTES(META), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .streaming(streaming), .cfg_en_wr(cfg_en_wr),
    .cfg_en_wdata(cfg_en_wdata), .en_state(en_state), .cfg_stretch(cfg_stretch),
    .cfg_line_len(cfg_line_len), .cfg_emb_dt(EMB_DT), .cfg_emb_vc(EMB_VC),
    .cfg_pix_dt(PIX_DT), .cfg_pix_vc(PIX_VC), .frame_start(frame_start),
    .status_words(sw_flat), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .pix_sol(pix_sol), .pix_eol(pix_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_dt(out_dt), .out_vc(out_vc), .out_sol(out_sol), .out_eol(out_eol)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;
  bit en_m = 1'b1;
  int fcnt_m = 0;
  logic [9:0] stat_q[$];
  logic [9:0] pix_q[$];
  bit stat_owed = 0, in_stat = 0, out_pix_open = 0, snap_test = 0;
  int sidx = 0;
  int ready_mode = 0;
  int cyc = 0;
  bit prev_hold = 0;
  logic [7:0] prev_data;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    out_ready <= (ready_mode == 0) ? 1'b1 : ((cyc % 5) != 3 && (cyc % 7) != 2);
  end

  function automatic logic [7:0] exp_byte(input int i, input int fc);
    if (i < 2) return 8'((fc >> (8 * i)) & 255);
    if (i < 2 + 4 * SW) return w[(i - 2) / 4][((i - 2) % 4) * 8 +: 8];
    if (i < META) return 8'h00;
    return 8'h07;
  endfunction

  task automatic build_line();
    int len;
    len = (cfg_stretch && cfg_line_len > LW'(META)) ? int'(cfg_line_len) : META;
    for (int i = 0; i < len; i++)
      stat_q.push_back({(i == 0), (i == len - 1), exp_byte(i, fcnt_m)});
  endtask

  task automatic frame_pulse();
    @(negedge clk);
    frame_start = 1'b1;
    if (streaming) begin
      if (en_m) begin build_line(); stat_owed = 1; end
      fcnt_m = (fcnt_m + 1) % 65536;
    end
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic send_line(input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_data = 8'((seed + k) & 255);
      pix_sol = (k == 0);
      pix_eol = (k == n - 1);
      forever begin
        #1;
        if (pix_ready) begin
          pix_q.push_back({pix_sol, pix_eol, pix_data});
          break;
        end
        @(negedge clk);
      end
    end
    @(negedge clk);
    pix_valid = 1'b0;
    pix_sol = 1'b0;
    pix_eol = 1'b0;
  endtask

  task automatic wait_idle();
    while (stat_q.size() != 0 || pix_q.size() != 0 || stat_owed || in_stat) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(stat_q.size() == 0 && pix_q.size() == 0, "R10", stat_q.size() + pix_q.size(), 0);
  endtask

  task automatic set_en(input bit v);
    @(negedge clk);
    cfg_en_wr = 1'b1;
    cfg_en_wdata = v;
    if (!streaming) en_m = v;
    @(negedge clk);
    cfg_en_wr = 1'b0;
  endtask

  // cycle-by-cycle comparison against the reference queues
  always begin
    @(negedge clk);
    #2;
    if (rst_n && !finished) begin
      // R12: a stalled metadata byte stays offered and unchanged
      if (prev_hold)
        chk(out_valid && out_data == prev_data, "R12", out_data, prev_data);
      prev_hold = out_valid && !out_ready && out_dt == EMB_DT && out_vc == EMB_VC;
      prev_data = out_data;
      // R10: no pixel byte taken while a metadata line is on the wire
      if (in_stat && pix_valid) chk(!pix_ready, "R10", pix_ready, 0);
      if (out_valid && out_ready) begin
        if (out_dt == EMB_DT && out_vc == EMB_VC) begin
          if (stat_q.size() == 0) begin
            chk(0, "R7", out_data, 0);
          end else begin
            logic [9:0] e;
            string tag;
            e = stat_q.pop_front();
            if (out_sol) sidx = 0;
            tag = (sidx < 2) ? "R9" : (sidx >= META) ? "R3" :
                  (snap_test && sidx < 2 + 4 * SW) ? "R6" : "R2";
            chk(out_data == e[7:0], tag, out_data, e[7:0]);
            chk({out_sol, out_eol} == e[9:8], "R5", {out_sol, out_eol}, e[9:8]);
            sidx++;
          end
          if (out_sol) begin
            chk(!out_pix_open, "R11", out_pix_open, 0);
            stat_owed = 0;
            in_stat = 1;
          end
          if (out_eol) in_stat = 0;
        end else begin
          chk(out_dt == PIX_DT && out_vc == PIX_VC, "R4", {out_dt, out_vc}, {PIX_DT, PIX_VC});
          if (out_sol) chk(!stat_owed, "R1", stat_owed, 0);
          if (pix_q.size() == 0) begin
            chk(0, "R10", out_data, 0);
          end else begin
            logic [9:0] p;
            p = pix_q.pop_front();
            chk({out_sol, out_eol, out_data} == p, "R10", {out_sol, out_eol, out_data}, p);
          end
          if (out_eol) out_pix_open = 0;
          else if (out_sol) out_pix_open = 1;
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      report();
    end
  end

  initial begin
    for (int k = 0; k < SW; k++) w[k] = 32'h11223344 + 32'(k) * 32'h01010101;
    repeat (4) @(negedge clk);
    // R13: reset state
    chk(out_valid == 1'b0, "R13", out_valid, 0);
    chk(en_state == 1'b1, "R13", en_state, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R13", out_valid, 0);

    // R9: frame start ignored while not streaming
    frame_pulse();
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R9", out_valid, 0);

    // R1, R6, R10: pixel lines offered during the metadata line; words change mid-line
    streaming = 1'b1;
    ready_mode = 1;
    snap_test = 1;
    fork
      frame_pulse();
      begin @(negedge clk); send_line(16, 8'h40); send_line(20, 8'h80); end
      begin repeat (6) @(negedge clk); for (int k = 0; k < SW; k++) w[k] = ~w[k]; end
    join
    wait_idle();
    snap_test = 0;

    // second frame, full-rate ready
    ready_mode = 0;
    fork
      frame_pulse();
      begin @(negedge clk); send_line(8, 8'h10); end
    join
    wait_idle();

    // R8: enable write during streaming is ignored
    set_en(1'b0);
    #1 chk(en_state == 1'b1, "R8", en_state, 1);
    ready_mode = 1;
    fork
      frame_pulse();
      begin @(negedge clk); send_line(5, 8'hA0); end
    join
    wait_idle();

    // R3: stretched line of 600 bytes
    streaming = 1'b0;
    cfg_stretch = 1'b1;
    cfg_line_len = LW'(600);
    @(negedge clk);
    streaming = 1'b1;
    frame_pulse();
    wait_idle();

    // R3: stretch with a length below 512 keeps 512
    streaming = 1'b0;
    cfg_line_len = LW'(300);
    @(negedge clk);
    streaming = 1'b1;
    frame_pulse();
    wait_idle();

    // R11: frame start inside a pixel line
    streaming = 1'b0;
    cfg_stretch = 1'b0;
    @(negedge clk);
    streaming = 1'b1;
    fork
      send_line(40, 8'h05);
      begin repeat (10) @(negedge clk); frame_pulse(); end
    join
    send_line(6, 8'hC0);
    wait_idle();

    // R7: insertion disabled
    streaming = 1'b0;
    set_en(1'b0);
    #1 chk(en_state == 1'b0, "R7", en_state, 0);
    streaming = 1'b1;
    fork
      frame_pulse();
      begin @(negedge clk); send_line(10, 8'h33); end
    join
    wait_idle();

    // R9: count to 65534 while disabled, then observe the wrap
    begin
      int n;
      n = 65534 - fcnt_m;
      @(negedge clk);
      frame_start = 1'b1;
      repeat (n) @(negedge clk);
      frame_start = 1'b0;
      fcnt_m = 65534;
    end
    chk(out_valid == 1'b0, "R7", out_valid, 0);
    streaming = 1'b0;
    set_en(1'b1);
    streaming = 1'b1;
    for (int f = 0; f < 3; f++) begin
      fork
        frame_pulse();
        begin @(negedge clk); send_line(4, f * 16); end
      join
      wait_idle();
    end
    chk(fcnt_m == 1, "R9", fcnt_m, 1);

    finished = 1'b1;
    report();
  end
endmodule